// File: doc/BRIEF.md
# CORDIC Phase-Difference FM Discriminator

This block turns a stream of complex baseband samples into an instantaneous-frequency signal. For every accepted I/Q pair it works out the sample's angle with a vectoring CORDIC that uses only shifts and adds. It then subtracts the angle of the previous sample and emits the signed difference, which is proportional to the frequency deviation of an FM carrier.

The core is iterative, with one micro-rotation per clock. It therefore suits low sample rates, such as a 192 kHz demodulator input, where hundreds of clocks are available per sample. Angles are kept as two's-complement binary angles in which 2^ANGLE_W counts make one full turn. Because of this encoding, the subtraction wraps modulo 2π with no extra logic. Samples in the left half plane are first negated, which is a rotation by π, and their angle accumulator starts at π. This lets the iterations converge for any input direction.

Top module: `fm_phase_discriminator`

## Requirements
- R1: After reset `out_valid` is low, and the stored previous angle is zero. The first output after reset is therefore the absolute angle of the first sample.
- R2: Each output equals angle(sample n) minus angle(sample n-1). Angles are binary angles, where 2^ANGLE_W counts are one turn and counts grow counter-clockwise from the positive I axis. The output must be within ±24 counts of the exact value for inputs of magnitude at least 1500 with the default parameters.
- R3: The angle is correct in all four quadrants. This includes inputs on the negative I axis and inputs just above and just below it.
- R4: The difference wraps modulo one turn as a two's-complement value. A step from +170° to -170° gives about +20°, and the reverse step gives about -20°.
- R5: `out_valid` rises exactly ITERATIONS clock edges after the edge that captures a sample, and it stays high for exactly one cycle.
- R6: A strobe on `in_valid` while a sample is being processed is ignored. It produces no output and does not change the stored previous angle.
- R7: A strobe presented in the same cycle that `out_valid` is high is accepted. Samples can therefore be issued back to back every ITERATIONS+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: in_i/in_q carry a new sample |
| in_i | input | SAMPLE_W | In-phase component, signed |
| in_q | input | SAMPLE_W | Quadrature component, signed |
| out_valid | output | 1 | One-cycle strobe: out_dphase is new |
| out_dphase | output | ANGLE_W | Signed angle change since the previous sample, binary angle units |

## Verification
The cases that are hardest to reach are the branch cut at ±π and the pre-rotation boundary at I=0. There the accumulator start value and the final subtraction must both wrap correctly. The bench reaches these cases with a dense angle sweep that lands on and next to both axes, and with explicit ±170° jumps across the cut. Strobes during a busy computation are produced by holding `in_valid` high with different data for several cycles after a capture. The bench then shows that the next difference is taken against the first sample only.

// File: rtl/fm_phase_discriminator.sv
module fm_phase_discriminator #(
  parameter int SAMPLE_W   = 12,
  parameter int ANGLE_W    = 16,
  parameter int ITERATIONS = 14,
  parameter int GUARD_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic                       out_valid,
  output logic signed [ANGLE_W-1:0]  out_dphase
);

  localparam int XW = SAMPLE_W + 2 + GUARD_W;
  localparam int ZW = ANGLE_W + 4;
  localparam int CW = $clog2(ITERATIONS + 1);

  function automatic logic [31:0] turn_frac(input int k);
    case (k)
      0:  turn_frac = 32'h20000000;
      1:  turn_frac = 32'h12E4051E;
      2:  turn_frac = 32'h09FB385B;
      3:  turn_frac = 32'h051111D4;
      4:  turn_frac = 32'h028B0D43;
      5:  turn_frac = 32'h0145D7E1;
      6:  turn_frac = 32'h00A2F61E;
      7:  turn_frac = 32'h00517C55;
      8:  turn_frac = 32'h0028BE53;
      9:  turn_frac = 32'h00145F2F;
      10: turn_frac = 32'h000A2F98;
      11: turn_frac = 32'h000517CC;
      12: turn_frac = 32'h00028BE6;
      13: turn_frac = 32'h000145F3;
      14: turn_frac = 32'h0000A2FA;
      15: turn_frac = 32'h0000517D;
      default: turn_frac = (k > 31) ? 32'd0 : 32'(64'd683565276 >> k);
    endcase
  endfunction

  function automatic logic [ZW-1:0] step_angle(input int k);
    logic [32:0] r;
    r = {1'b0, turn_frac(k)} + (33'd1 << (31 - ZW));
    step_angle = ZW'(r >> (32 - ZW));
  endfunction

  logic                   busy;
  logic [CW-1:0]          cnt;
  logic signed [XW-1:0]   x, y;
  logic [ZW-1:0]          z;
  logic [ANGLE_W-1:0]     prev;

  wire signed [XW-1:0] xs = {{2{in_i[SAMPLE_W-1]}}, in_i, {GUARD_W{1'b0}}};
  wire signed [XW-1:0] ys = {{2{in_q[SAMPLE_W-1]}}, in_q, {GUARD_W{1'b0}}};
  wire                 left = in_i[SAMPLE_W-1];

  wire signed [XW-1:0] x_sh = x >>> cnt;
  wire signed [XW-1:0] y_sh = y >>> cnt;
  wire                 up   = !y[XW-1];
  wire [ZW-1:0]        stp  = step_angle(int'(cnt));
  wire                 last = (cnt == CW'(ITERATIONS - 1));

  wire signed [XW-1:0] x_nx = up ? x + y_sh : x - y_sh;
  wire signed [XW-1:0] y_nx = up ? y - x_sh : y + x_sh;
  wire [ZW-1:0]        z_nx = up ? z + stp : z - stp;

  wire [ZW-1:0]        z_rnd     = z_nx + ZW'(1 << (ZW - ANGLE_W - 1));
  wire [ANGLE_W-1:0]   phase_new = z_rnd[ZW-1 -: ANGLE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      x          <= '0;
      y          <= '0;
      z          <= '0;
      prev       <= '0;
      out_valid  <= 1'b0;
      out_dphase <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        x   <= x_nx;
        y   <= y_nx;
        z   <= z_nx;
        cnt <= cnt + CW'(1);
        if (last) begin
          busy       <= 1'b0;
          out_valid  <= 1'b1;
          out_dphase <= phase_new - prev;
          prev       <= phase_new;
        end
      end else if (in_valid) begin
        x    <= left ? -xs : xs;
        y    <= left ? -ys : ys;
        z    <= left ? {1'b1, {(ZW-1){1'b0}}} : '0;
        cnt  <= '0;
        busy <= 1'b1;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                                          // R5
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));                                  // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && $stable(prev));                           // R6
  AST_X_RIGHT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !x[XW-1]);                                                 // R3
  AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && in_valid |=> busy);                                        // R7

endmodule

// File: tb/test_fm_phase_discriminator.sv
module test_fm_phase_discriminator;
  localparam int  CLK_PERIOD = 10;
  localparam int  ITER = 14;
  localparam real TOL  = 24.0;
  localparam real PI   = 3.14159265358979;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic signed [11:0] in_i = 0, in_q = 0;
  logic out_valid;
  logic signed [15:0] out_dphase;

  int  n_tests = 0, n_fail = 0;
  bit  done = 0;
  real exp_prev = 0.0;

  fm_phase_discriminator #(.SAMPLE_W(12), .ANGLE_W(16), .ITERATIONS(ITER), .GUARD_W(6)) i_fm_phase_discriminator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_dphase(out_dphase));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic real ang_cnt(input int vi, input int vq);
    return $atan2(real'(vq), real'(vi)) * 65536.0 / (2.0 * PI);
  endfunction

  function automatic real wrap(input real d);
    return d - 65536.0 * $floor(d / 65536.0 + 0.5);
  endfunction

  task automatic check(input string tag, input bit ok, input real act, input real exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0.1f expected=%0.1f", tag, act, exp);
    end
  endtask

  task automatic send(input int vi, input int vq, output int lat, output real res);
    in_i = 12'(vi); in_q = 12'(vq); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    res = real'(out_dphase);
  endtask

  task automatic sample(input string tag, input int vi, input int vq);
    int  lat;
    real res, cur, e;
    send(vi, vq, lat, res);
    cur = ang_cnt(vi, vq);
    e = wrap(cur - exp_prev);
    exp_prev = cur;
    check({tag, " latency"}, lat == ITER, real'(lat), real'(ITER));
    check(tag, (wrap(res - e) <= TOL) && (wrap(res - e) >= -TOL), res, e);
  endtask

  task automatic polar(input string tag, input real deg, input real mag);
    sample(tag, $rtoi(mag * $cos(deg * PI / 180.0)), $rtoi(mag * $sin(deg * PI / 180.0)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int  lat, outs;
    real res, e, a_ang;
    repeat (3) @(negedge clk);
    check("R1 out_valid low in reset", out_valid == 0, real'(out_valid), 0.0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid low after reset", out_valid == 0, real'(out_valid), 0.0);

    polar("R1 first output is absolute angle", 30.0, 1800.0);

    for (int k = 0; k < 60; k++) polar("R2 sweep", -180.0 + real'(k) * 6.1, 1500.0 + real'(k % 5) * 100.0);

    sample("R3 +I axis", 1800, 0);
    sample("R3 +Q axis", 0, 1800);
    sample("R3 -I axis", -1800, 0);
    sample("R3 below -I axis", -1800, -1);
    sample("R3 above -I axis", -1800, 1);
    sample("R3 -Q axis", 0, -1800);
    sample("R3 most negative I", -2048, 0);
    sample("R3 corner", 2047, -2048);
    sample("R3 corner", -2048, -2048);
    sample("R3 corner", -2048, 2047);

    polar("R4 setup", 170.0, 1800.0);
    polar("R4 wrap forward", -170.0, 1800.0);
    check("R4 forward near +20deg", (res_near(out_dphase, 3641.0)), real'(out_dphase), 3641.0);
    polar("R4 wrap backward", 170.0, 1800.0);
    check("R4 backward near -20deg", (res_near(out_dphase, -3641.0)), real'(out_dphase), -3641.0);
    polar("R4 half-turn jump", -10.0, 1800.0);

    polar("R5 setup", 45.0, 1800.0);
    @(negedge clk);
    check("R5 one-cycle pulse", out_valid == 0, real'(out_valid), 0.0);

    in_i = 12'(1800); in_q = 12'(0); in_valid = 1;
    @(negedge clk);
    in_i = -12'sd1000; in_q = 12'(1500);
    repeat (4) @(negedge clk);
    in_valid = 0;
    outs = 0;
    for (int c = 0; c < 3 * ITER; c++) begin
      if (out_valid) begin
        outs++;
        res = real'(out_dphase);
      end
      @(negedge clk);
    end
    a_ang = ang_cnt(1800, 0);
    e = wrap(a_ang - exp_prev);
    exp_prev = a_ang;
    check("R6 single output despite busy strobes", outs == 1, real'(outs), 1.0);
    check("R6 output reflects first sample", (wrap(res - e) <= TOL) && (wrap(res - e) >= -TOL), res, e);
    sample("R6 next diff against first sample", 0, -1700);

    polar("R7 back-to-back A", 100.0, 1700.0);
    polar("R7 back-to-back B", -60.0, 1700.0);
    polar("R7 back-to-back C", 135.0, 1700.0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic bit res_near(input logic signed [15:0] v, input real target);
    real d;
    d = wrap(real'(v) - target);
    return (d <= 2.0 * TOL) && (d >= -2.0 * TOL);
  endfunction

endmodule